// File: doc/BRIEF.md
# Pulse-and-Verify Word Programming Sequencer

This block sits on the host side of a memory whose bits can only be cleared by programming. The bits start at one, and a program pulse on chip enable clears the bits that are zero in the presented data word. Given a start command, a base address and a word count, the sequencer fetches each word from a data source port by index. It drives address and data, fires a chip-enable pulse of fixed length, then switches to a read with output enable low and compares the returned word with the source. A mismatch costs another pulse. The sequencer gives up on a word after a fixed number of failed verifies.

Once every word has verified, the sequencer reads the whole block once more and compares each word again. Only after that pass does it report done. All delays are given in nanoseconds and converted to clock cycles from the clock frequency parameter, rounding up. The high programming voltage is not switched here. A status output tells the board when that voltage is needed.

Top module: `pgm_sequencer`

## Requirements
- R1: After reset, chip enable and output enable are high (inactive), data is not driven, and busy, done, fail, fail_final and the voltage request are all 0.
- R2: Every program pulse holds chip enable low for exactly ceil(50 us × clock) cycles, which lies inside the 45–55 us window. Output enable stays high during the pulse.
- R3: Address and data are driven and unchanged for at least ceil(2 us) cycles before chip enable falls. The data stays driven for at least ceil(2 us) cycles after chip enable rises.
- R4: Output enable goes low only while chip enable is high and the data bus is released. Each verify read starts at least ceil(2 us) + ceil(2 us) cycles after the end of the pulse before it.
- R5: After a failed verify, the same word gets another pulse. A word receives exactly as many pulses as it needs to read back correctly. No further pulse follows a passing verify.
- R6: When the 25th verify of one word fails, the sequence stops: fail = 1, fail_final = 0, fail_addr holds the address of that word, and no further chip-enable pulse or later word follows.
- R7: A word that reads back correctly on its 25th verify is accepted, and the sequence completes with done.
- R8: After the last word verifies, every word of the block is read once more. When all of them match, done = 1 and fail = 0. Done and fail are never both 1.
- R9: A mismatch in the final pass stops the sequence with fail = 1, fail_final = 1 and fail_addr equal to the mismatching address.
- R10: Read data is compared only after output enable has been low for ceil(120 ns) cycles.
- R11: A start with word count 0 reports done without any memory cycle.
- R12: The voltage request output is 1 whenever chip enable is low. It is 0 during the final read pass and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency CLK_MHZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, taken only while idle |
| start_addr_i | input | AW | Memory address of the first word |
| word_count_i | input | AW | Number of words to program |
| src_idx_o | output | AW | Index of the word requested from the source |
| src_data_i | input | DW | Source word for src_idx_o, combinational |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Data to program (zero when not driven) |
| mem_wdrive_o | output | 1 | Data bus driven by the sequencer |
| mem_ce_n_o | output | 1 | Chip enable, active low, the program pulse |
| mem_oe_n_o | output | 1 | Output enable, active low, for reads |
| mem_rdata_i | input | DW | Data read from the memory |
| vpp_req_o | output | 1 | Programming voltage needed |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Block programmed and checked, held until next start |
| fail_o | output | 1 | Sequence stopped on error, held until next start |
| fail_final_o | output | 1 | The failure was found in the final pass |
| fail_addr_o | output | AW | Address of the failing word |

## Verification
The bench's memory model needs a chosen number of pulses per word before a word takes its data, so the retry count per word is known in advance. Four mixes are applied: words needing one to three pulses, a word needing exactly the limit, a word needing one pulse past the limit, and a word that is corrupted by programming its neighbour after it has passed. Together these separate correct retry counting from off-by-one limits and tell a per-word failure apart from a final-pass failure. The model also returns inverted data until output enable has been low long enough, so early sampling shows up as extra pulses. A zero-length block checks that no memory cycle is issued.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_RECOV,
    ST_VERIFY,
    ST_FGAP,
    ST_FREAD
  } seq_state_t;

  // Analog timing targets in nanoseconds
  localparam int unsigned PULSE_NS  = 50000;
  localparam int unsigned SETUP_NS  = 2000;
  localparam int unsigned HOLD_NS   = 2000;
  localparam int unsigned RECOV_NS  = 2000;
  localparam int unsigned OVALID_NS = 120;

  // Nanoseconds to clock cycles, rounded up, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/pgm_phase_timer.sv
module pgm_phase_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  assign expire = (cnt_q == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (!expire) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/pgm_index_ctr.sv
module pgm_index_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] count,
  output logic [W-1:0] idx,
  output logic         last
);
  logic [W-1:0] idx_q;

  assign idx  = idx_q;
  assign last = (idx_q == count - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (clear) idx_q <= '0;
    else if (step)  idx_q <= idx_q + W'(1);
  end
endmodule

// File: rtl/pgm_try_ctr.sv
module pgm_try_ctr #(
  parameter int unsigned MAX_TRIES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic exhausted
);
  localparam int unsigned TW = $clog2(MAX_TRIES + 1);
  logic [TW-1:0] tries_q;

  // high when the verify now being judged is the last one allowed
  assign exhausted = (tries_q == TW'(MAX_TRIES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tries_q <= '0;
    else if (clear) tries_q <= '0;
    else if (step)  tries_q <= tries_q + TW'(1);
  end
endmodule

// File: rtl/pgm_sequencer.sv
module pgm_sequencer
  import pgm_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 125,
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 16,
  parameter int unsigned MAX_TRIES = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [AW-1:0] word_count_i,
  output logic [AW-1:0] src_idx_o,
  input  logic [DW-1:0] src_data_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_wdrive_o,
  output logic          mem_ce_n_o,
  output logic          mem_oe_n_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          vpp_req_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          fail_final_o,
  output logic [AW-1:0] fail_addr_o
);
  localparam int unsigned T_PULSE  = ns_to_cyc(PULSE_NS,  CLK_MHZ);
  localparam int unsigned T_SETUP  = ns_to_cyc(SETUP_NS,  CLK_MHZ);
  localparam int unsigned T_HOLD   = ns_to_cyc(HOLD_NS,   CLK_MHZ);
  localparam int unsigned T_RECOV  = ns_to_cyc(RECOV_NS,  CLK_MHZ);
  localparam int unsigned T_OVALID = ns_to_cyc(OVALID_NS, CLK_MHZ);
  localparam int unsigned CW       = $clog2(T_PULSE + 1);

  // Length of each timed state in cycles
  function automatic logic [CW-1:0] phase_len(input seq_state_t s);
    case (s)
      ST_SETUP:            return CW'(T_SETUP);
      ST_PULSE:            return CW'(T_PULSE);
      ST_HOLD:             return CW'(T_HOLD);
      ST_RECOV:            return CW'(T_RECOV);
      ST_VERIFY, ST_FREAD: return CW'(T_OVALID);
      default:             return CW'(1);
    endcase
  endfunction

  seq_state_t    state_q, state_d;
  logic [AW-1:0] base_q, count_q, faddr_q, idx;
  logic          done_q, fail_q, final_q;
  logic          expire, last, exhausted, rd_match;

  // Named internal events
  logic ev_start, ev_verify_pass, ev_verify_miss, ev_give_up;
  logic ev_final_pass, ev_final_miss;

  assign rd_match       = (mem_rdata_i == src_data_i);
  assign ev_start       = (state_q == ST_IDLE) && start_i;
  assign ev_verify_pass = (state_q == ST_VERIFY) && expire && rd_match;
  assign ev_verify_miss = (state_q == ST_VERIFY) && expire && !rd_match;
  assign ev_give_up     = ev_verify_miss && exhausted;
  assign ev_final_pass  = (state_q == ST_FREAD) && expire && rd_match;
  assign ev_final_miss  = (state_q == ST_FREAD) && expire && !rd_match;

  pgm_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(state_d != state_q),
    .limit(phase_len(state_q)), .expire(expire)
  );

  pgm_index_ctr #(.W(AW)) u_index (
    .clk(clk), .rst_n(rst_n),
    .clear(ev_start || (ev_verify_pass && last)),
    .step((ev_verify_pass || ev_final_pass) && !last),
    .count(count_q), .idx(idx), .last(last)
  );

  pgm_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk(clk), .rst_n(rst_n),
    .clear((state_q == ST_IDLE) || ev_verify_pass),
    .step(ev_verify_miss), .exhausted(exhausted)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start_i && (word_count_i != '0)) state_d = ST_SETUP;
      ST_SETUP:  if (expire) state_d = ST_PULSE;
      ST_PULSE:  if (expire) state_d = ST_HOLD;
      ST_HOLD:   if (expire) state_d = ST_RECOV;
      ST_RECOV:  if (expire) state_d = ST_VERIFY;
      ST_VERIFY: begin
        if (ev_verify_pass)      state_d = last ? ST_FGAP : ST_SETUP;
        else if (ev_verify_miss) state_d = exhausted ? ST_IDLE : ST_SETUP;
      end
      ST_FGAP:   if (expire) state_d = ST_FREAD;
      ST_FREAD: begin
        if (ev_final_pass)      state_d = last ? ST_IDLE : ST_FGAP;
        else if (ev_final_miss) state_d = ST_IDLE;
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      count_q <= '0;
      faddr_q <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      final_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_start) begin
        base_q  <= start_addr_i;
        count_q <= word_count_i;
        faddr_q <= '0;
        done_q  <= (word_count_i == '0);
        fail_q  <= 1'b0;
        final_q <= 1'b0;
      end
      if (ev_give_up) begin
        fail_q  <= 1'b1;
        faddr_q <= mem_addr_o;
      end
      if (ev_final_miss) begin
        fail_q  <= 1'b1;
        final_q <= 1'b1;
        faddr_q <= mem_addr_o;
      end
      if (ev_final_pass && last) done_q <= 1'b1;
    end
  end

  assign src_idx_o    = idx;
  assign mem_addr_o   = base_q + idx;
  assign mem_wdrive_o = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign mem_wdata_o  = mem_wdrive_o ? src_data_i : '0;
  assign mem_ce_n_o   = (state_q != ST_PULSE);
  assign mem_oe_n_o   = !((state_q == ST_VERIFY) || (state_q == ST_FREAD));
  assign vpp_req_o    = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD)
                     || (state_q == ST_RECOV) || (state_q == ST_VERIFY);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign fail_o       = fail_q;
  assign fail_final_o = final_q;
  assign fail_addr_o  = faddr_q;
endmodule

// File: rtl/pgm_seq_checker.sv
module pgm_seq_checker
  import pgm_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 125,
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_wdrive_o,
  input logic          mem_ce_n_o,
  input logic          mem_oe_n_o,
  input logic          vpp_req_o,
  input logic          done_o,
  input logic          fail_o,
  input logic          fail_final_o,
  input logic [AW-1:0] fail_addr_o,
  input logic          ev_give_up,
  input logic          ev_final_miss
);
  localparam int unsigned C_PULSE = ns_to_cyc(PULSE_NS, CLK_MHZ);
  localparam int unsigned C_SETUP = ns_to_cyc(SETUP_NS, CLK_MHZ);

  logic [31:0]   low_run, stable_run;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run    <= '0;
      stable_run <= '0;
      prev_addr  <= '0;
      prev_data  <= '0;
    end else begin
      low_run <= mem_ce_n_o ? '0 : low_run + 32'd1;
      if (mem_wdrive_o && mem_addr_o == prev_addr && mem_wdata_o == prev_data) begin
        if (stable_run != '1) stable_run <= stable_run + 32'd1;
      end else begin
        stable_run <= '0;
      end
      prev_addr <= mem_addr_o;
      prev_data <= mem_wdata_o;
    end
  end

  // the edge that first sees the values changed is not counted, hence one less
  assert_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n_o) |-> (stable_run >= C_SETUP - 1));

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n_o) |-> (low_run == C_PULSE));

  assert_no_read_in_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n_o |-> mem_oe_n_o);

  assert_bus_free_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n_o |-> !mem_wdrive_o);

  assert_give_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_give_up |=> (fail_o && !fail_final_o && mem_ce_n_o));

  assert_fail_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_i) |=> (fail_o && $stable(fail_addr_o)));

  assert_done_xor_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, fail_o}));

  assert_final_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_final_miss |=> (fail_o && fail_final_o));

  assert_vpp_in_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n_o |-> vpp_req_o);
endmodule

bind pgm_sequencer pgm_seq_checker #(
  .CLK_MHZ(CLK_MHZ), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_wdrive_o(mem_wdrive_o),
  .mem_ce_n_o(mem_ce_n_o), .mem_oe_n_o(mem_oe_n_o), .vpp_req_o(vpp_req_o),
  .done_o(done_o), .fail_o(fail_o), .fail_final_o(fail_final_o),
  .fail_addr_o(fail_addr_o), .ev_give_up(ev_give_up), .ev_final_miss(ev_final_miss)
);

// File: tb/tb_pgm_sequencer.sv
`timescale 1ns/1ps
module tb_pgm_sequencer;
  localparam int MHZ    = 10;   // timing parameter, compressed so the run stays short
  localparam int PW_CYC = 50 * MHZ;
  localparam int SU_CYC = 2 * MHZ;
  localparam int OV_CYC = (120 * MHZ + 999) / 1000;

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0]  start_addr = '0, word_count = '0, src_idx, mem_addr, fail_addr;
  logic [15:0] src_data, mem_wdata, mem_rdata;
  logic mem_wdrive, mem_ce_n, mem_oe_n, vpp, busy, done, fail, fail_final;

  always #4 clk = ~clk;

  pgm_sequencer #(.CLK_MHZ(MHZ), .AW(8), .DW(16), .MAX_TRIES(25)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
    .word_count_i(word_count), .src_idx_o(src_idx), .src_data_i(src_data),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_wdrive_o(mem_wdrive),
    .mem_ce_n_o(mem_ce_n), .mem_oe_n_o(mem_oe_n), .mem_rdata_i(mem_rdata),
    .vpp_req_o(vpp), .busy_o(busy), .done_o(done), .fail_o(fail),
    .fail_final_o(fail_final), .fail_addr_o(fail_addr)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // ---------------- memory model: bits only clear, word takes data after need[] pulses
  logic [15:0] mem [256];
  logic [15:0] src [256];
  int need [256], pulses [256], reads [256];
  bit dist_en = 0;
  logic [7:0] dist_a = '0;
  logic ce_q = 1, oe_q = 1;
  int oe_cnt = 0;

  assign src_data  = src[src_idx];
  assign mem_rdata = (oe_cnt >= OV_CYC - 1) ? mem[mem_addr] : ~mem[mem_addr];

  always @(posedge clk) begin
    if (!ce_q && mem_ce_n) begin
      pulses[mem_addr]++;
      if (pulses[mem_addr] >= need[mem_addr]) mem[mem_addr] <= mem[mem_addr] & mem_wdata;
      if (dist_en && mem_addr == dist_a + 8'd1) mem[dist_a] <= mem[dist_a] & 16'hFFFE;
    end
    if (!mem_oe_n && oe_q) reads[mem_addr]++;
    ce_q   <= mem_ce_n;
    oe_q   <= mem_oe_n;
    oe_cnt <= mem_oe_n ? 0 : oe_cnt + 1;
  end

  task automatic erase();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'hFFFF; pulses[i] = 0; reads[i] = 0; need[i] = 1;
    end
    dist_en = 0;
  endtask

  // ---------------- timing monitor at the falling edge
  int stab = 0, low_run = 0, hold_run = 0, since_rise = 0;
  bit in_hold = 0, ce_p = 1, oe_p = 1;
  logic [7:0]  la = '0;
  logic [15:0] ld = '0;
  int viol_pw = 0, viol_su = 0, viol_hold = 0, viol_rec = 0, viol_oe = 0, viol_vpp = 0;
  int n_pulse_obs = 0, n_verify_rd = 0, n_final_rd = 0;

  always @(negedge clk) if (rst_n) begin
    if (!mem_ce_n) low_run++;
    else if (!ce_p) begin
      n_pulse_obs++;
      if (low_run != PW_CYC) viol_pw++;
      low_run = 0;
    end
    if (!mem_ce_n && ce_p && stab < SU_CYC) viol_su++;
    if (mem_wdrive && mem_addr == la && mem_wdata == ld) stab++;
    else stab = mem_wdrive ? 1 : 0;
    la = mem_addr; ld = mem_wdata;
    if (mem_ce_n && !ce_p) begin in_hold = 1; hold_run = 0; since_rise = 0; end
    if (in_hold) begin
      if (mem_wdrive) hold_run++;
      else begin
        if (hold_run < SU_CYC) viol_hold++;
        in_hold = 0;
      end
    end
    if (!mem_oe_n && oe_p) begin
      if (vpp) begin
        n_verify_rd++;
        if (since_rise < 2 * SU_CYC) viol_rec++;
      end else n_final_rd++;
    end
    if (mem_ce_n) since_rise++;
    if (!mem_oe_n && (mem_wdrive || !mem_ce_n)) viol_oe++;
    if (!mem_ce_n && !vpp) viol_vpp++;
    ce_p = mem_ce_n; oe_p = mem_oe_n;
  end

  // ---------------- scoreboard
  typedef struct packed { logic f; logic fin; logic [7:0] addr; } exp_t;
  exp_t  sbq [$];
  string tagq [$];
  bit armed = 0;

  always @(negedge clk) begin
    if (armed && !busy && (done || fail)) begin
      exp_t e;
      string t;
      e = sbq.pop_front();
      t = tagq.pop_front();
      chk(fail == e.f, t, "fail flag", fail, e.f);
      chk(done == !e.f, t, "done flag", done, !e.f);
      chk(fail_final == e.fin, t, "final-pass flag", fail_final, e.fin);
      if (e.f) chk(fail_addr == e.addr, t, "fail address", fail_addr, e.addr);
      armed = 0;
    end
  end

  task automatic run_seq(input logic [7:0] base, input logic [7:0] cnt, input bit e_fail,
                         input bit e_fin, input logic [7:0] e_addr, input string tag);
    exp_t e;
    e.f = e_fail; e.fin = e_fin; e.addr = e_addr;
    sbq.push_back(e);
    tagq.push_back(tag);
    @(negedge clk);
    start_addr = base; word_count = cnt; start = 1;
    @(negedge clk);
    start = 0; armed = 1;
    while (armed) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not end");
    wrap_up();
  end

  initial begin
    int p0, v0;
    erase();
    for (int i = 0; i < 256; i++) src[i] = '0;
    repeat (5) @(negedge clk);
    // R1: idle outputs after reset
    chk(mem_ce_n && mem_oe_n, "R1", "ce_n&oe_n", {mem_ce_n, mem_oe_n}, 3);
    chk(!mem_wdrive && !vpp, "R1", "wdrive|vpp", {mem_wdrive, vpp}, 0);
    chk(!busy && !done && !fail && !fail_final, "R1", "status", {busy, done, fail, fail_final}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!busy && mem_ce_n, "R1", "idle after release", busy, 0);

    // T1: mixed retry counts; R5 R10 R8
    erase();
    src[0] = 16'hA5C3; src[1] = 16'h0F0F; src[2] = 16'hFFFE; src[3] = 16'h1234;
    need[8'h10] = 1; need[8'h11] = 3; need[8'h12] = 1; need[8'h13] = 2;
    run_seq(8'h10, 8'd4, 0, 0, 8'h00, "R8");
    for (int i = 0; i < 4; i++) begin
      chk(pulses[8'h10 + i] == need[8'h10 + i], "R5 R10", "pulses per word",
          pulses[8'h10 + i], need[8'h10 + i]);
      chk(mem[8'h10 + i] == src[i], "R5", "programmed word", mem[8'h10 + i], src[i]);
      chk(reads[8'h10 + i] == need[8'h10 + i] + 1, "R8", "verify+final reads",
          reads[8'h10 + i], need[8'h10 + i] + 1);
    end

    // T2: word needing exactly the limit; R7
    erase();
    src[0] = 16'h5A5A; src[1] = 16'h00FF;
    need[8'h80] = 25;
    run_seq(8'h80, 8'd2, 0, 0, 8'h00, "R7");
    chk(pulses[8'h80] == 25, "R7", "pulses on limit word", pulses[8'h80], 25);
    chk(mem[8'h81] == 16'h00FF, "R7", "next word written", mem[8'h81], 16'h00FF);

    // T3: word needing one pulse past the limit; R6
    erase();
    src[0] = 16'h1111; src[1] = 16'h2222; src[2] = 16'h3333;
    need[8'h21] = 26;
    run_seq(8'h20, 8'd3, 1, 0, 8'h21, "R6");
    p0 = n_pulse_obs;
    repeat (200) @(negedge clk);
    chk(pulses[8'h21] == 25, "R6", "pulses before giving up", pulses[8'h21], 25);
    chk(pulses[8'h22] == 0, "R6", "later word untouched", pulses[8'h22], 0);
    chk(n_pulse_obs == p0 && !busy, "R6", "no pulse after stop", n_pulse_obs, p0);

    // T4: earlier word corrupted by a neighbour's pulse; R9
    erase();
    src[0] = 16'h00FF; src[1] = 16'hF0F0; src[2] = 16'h0000;
    dist_en = 1; dist_a = 8'h40;
    run_seq(8'h40, 8'd3, 1, 1, 8'h40, "R9");
    chk(pulses[8'h42] == 1, "R9", "all words pulsed before final pass", pulses[8'h42], 1);

    // T5: zero-length block; R11
    erase();
    p0 = n_pulse_obs; v0 = n_verify_rd + n_final_rd;
    run_seq(8'h00, 8'd0, 0, 0, 8'h00, "R11");
    chk(n_pulse_obs == p0, "R11", "no pulse", n_pulse_obs, p0);
    chk(n_verify_rd + n_final_rd == v0, "R11", "no read", n_verify_rd + n_final_rd, v0);

    // global timing and flag observations
    chk(viol_pw == 0, "R2", "pulse width violations", viol_pw, 0);
    chk(n_pulse_obs == 62, "R2", "pulses seen", n_pulse_obs, 62);
    chk(viol_su == 0, "R3", "setup violations", viol_su, 0);
    chk(viol_hold == 0, "R3", "hold violations", viol_hold, 0);
    chk(viol_rec == 0, "R4", "pulse-to-read gap violations", viol_rec, 0);
    chk(viol_oe == 0, "R4", "read overlap violations", viol_oe, 0);
    chk(viol_vpp == 0, "R12", "pulse without voltage request", viol_vpp, 0);
    chk(n_final_rd == 7, "R12", "final reads with request low", n_final_rd, 7);
    chk(n_verify_rd == 62, "R5", "verify reads", n_verify_rd, 62);
    wrap_up();
  end
endmodule